// File: doc/BRIEF.md
# Programmable Interval Timer with Prescaler

This block is the timer slice of a small peripheral that also holds RAM and parallel ports. A bus write to one of the timer addresses loads an 8-bit count. The same write picks the prescale interval from the two lowest address bits and sets or clears the timer interrupt enable from address bit 3. The count then falls by one every interval. When a tick arrives while the count is already zero, the count wraps to 0xFF and a sticky timer flag is raised. From then on the count falls on every clock, whatever interval was chosen, so software can measure how long ago the timer expired.

The bus can read the live count and a status byte. A shared interrupt request output combines the timer source with the edge-detect source owned by the neighbouring port logic. That neighbour's flag and enable enter this block as inputs. Any later write to a timer address clears the timer flag, reloads the count and restarts the prescaler. After reset the timer sits idle at zero until it is first written.

Top module: `interval_timer`

## Requirements
- R1: A write whose address has bit 4 and bit 2 set (0x14–0x17, 0x1C–0x1F) loads the write data as the count. Reading any address whose low three bits are 100 returns the count, and a load of 128 reads 127 one clock later at the 1-clock interval.
- R2: Address bits [1:0] of the loading write select the interval: 00 gives 1 clock, 01 gives 8, 10 gives 64 and 11 gives 1024. With interval N the count holds for N−1 clocks after the write and falls by one on the Nth.
- R3: Every timer write restarts the prescaler, so the first decrement comes a full interval after the most recent write.
- R4: The count reaching zero raises no flag. The timer flag is set by the next tick taken at zero, and that tick wraps the count to 0xFF.
- R5: While the timer flag is set, the count falls by one on every clock, independent of the selected interval.
- R6: Address bit 3 of the loading write sets the timer interrupt enable and a clear bit 3 clears it. A disabled timer still sets its flag but does not drive the interrupt request.
- R7: Reading any address whose low three bits are 101 returns a status byte with the timer flag in bit 7, the edge-detect flag input in bit 6, and zeros elsewhere. Other read offsets return 0.
- R8: Any timer write clears the timer flag, so the timer's contribution to the interrupt request drops in the cycle after the write.
- R9: The interrupt request is high exactly when the timer flag and timer enable are both set, or the edge flag and edge enable inputs are both set.
- R10: Writes whose address has bit 4 or bit 2 clear leave the count, the flag and the enable untouched.
- R11: Active-low synchronous reset clears the count, the flag and the enable and holds the timer idle. The count stays 0 and no flag rises until the first timer write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 5 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| edge_flag | input | 1 | Edge-detect flag from the port logic |
| edge_en | input | 1 | Edge-detect interrupt enable from the port logic |
| irq | output | 1 | Shared interrupt request, active high |

## Verification
Several rules are checked on every cycle by the assertions. A load takes the written value, clears the flag and latches the enable. The count holds between prescaler ticks and falls every clock once the flag is up. The flag only rises from a zero count. An enabled, flagged timer always drives the request, and an idle timer stays at zero. Other properties need a full scenario and are shown only by the bench. These are the exact clock on which each of the four intervals first decrements, the prescaler restart on a rewrite, the run from a late-expired timer down to 0xFA, the status byte layout, and the writes that must be ignored.

// File: rtl/interval_timer_pkg.sv
// Package: shared constants for the interval timer.
// Assumes a 5-bit register address whose low three bits select the read register.
package interval_timer_pkg;

    // Low address bits that select the read registers
    localparam logic [2:0] RD_OFS_COUNT  = 3'b100;
    localparam logic [2:0] RD_OFS_STATUS = 3'b101;

    // Address bit positions used by the timer write decode
    localparam int unsigned ADR_BIT_GROUP  = 4;
    localparam int unsigned ADR_BIT_TIMER  = 2;
    localparam int unsigned ADR_BIT_IRQ_EN = 3;

    // Status byte bit positions
    localparam int unsigned STS_BIT_TIMER = 7;
    localparam int unsigned STS_BIT_EDGE  = 6;

    // Interval selector carried from the write address
    typedef enum logic [1:0] {
        IVL_1    = 2'b00,
        IVL_8    = 2'b01,
        IVL_64   = 2'b10,
        IVL_1024 = 2'b11
    } ivl_sel_t;

endpackage

// File: rtl/tmr_bus_decode.sv
// Module: tmr_bus_decode
// Decodes timer writes from the bus address and builds the read data.
// Assumes reads are combinational and have no side effects on timer state.
module tmr_bus_decode
    import interval_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] count,
    input  logic              timer_flag,
    input  logic              edge_flag,
    output logic              load,
    output ivl_sel_t          sel,
    output logic              en_wr,
    output logic [DATA_W-1:0] bus_rdata
);

    // Purpose: a write is a timer load when the group and timer address bits are set
    always_comb begin
        load  = bus_wr && bus_addr[ADR_BIT_GROUP] && bus_addr[ADR_BIT_TIMER];
        sel   = ivl_sel_t'(bus_addr[1:0]);
        en_wr = bus_addr[ADR_BIT_IRQ_EN];
    end

    // Purpose: read mux for the count and status registers
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr[2:0])
            RD_OFS_COUNT: bus_rdata = count;
            RD_OFS_STATUS: begin
                bus_rdata[STS_BIT_TIMER] = timer_flag;
                bus_rdata[STS_BIT_EDGE]  = edge_flag;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_prescaler.sv
// Module: tmr_prescaler
// Divides the clock by one of four powers of two and emits a one-cycle tick.
// Assumes SHIFTS is ascending; the last entry sets the divider width.
// After expiry (fast=1) a tick is issued on every clock.
module tmr_prescaler
    import interval_timer_pkg::*;
#(
    parameter int unsigned SHIFTS [4] = '{0, 3, 6, 10}
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  ivl_sel_t sel,
    input  logic     fast,
    output logic     tick
);

    localparam int unsigned PRE_W = (SHIFTS[3] > 0) ? SHIFTS[3] : 1;

    logic [PRE_W-1:0] lim [4];
    logic [PRE_W-1:0] pre_cnt;
    ivl_sel_t         sel_q;

    // Purpose: terminal value for each selectable interval
    for (genvar gi = 0; gi < 4; gi++) begin : g_lim
        assign lim[gi] = PRE_W'((64'd1 << SHIFTS[gi]) - 64'd1);
    end

    // Purpose: tick on the terminal count, or on every clock after expiry
    always_comb tick = fast || (pre_cnt == lim[sel_q]);

    // Purpose: divider state, restarted and re-selected on each load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            sel_q   <= IVL_1;
        end else if (load) begin
            pre_cnt <= '0;
            sel_q   <= sel;
        end else if (tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    AST_RESTART_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pre_cnt == '0)); // R3

endmodule

// File: rtl/tmr_counter.sv
// Module: tmr_counter
// Holds the down-count, the sticky expiry flag and the running state.
// Assumes tick comes from the prescaler and load from the bus decode.
module tmr_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] wdata,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic             running
);

    // Purpose: load, decrement on tick, and raise the flag when a tick finds zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            flag    <= 1'b0;
            running <= 1'b0;
        end else if (load) begin
            count   <= wdata;
            flag    <= 1'b0;
            running <= 1'b1;
        end else if (running && tick) begin
            count <= count - 1'b1;
            if (count == '0) begin
                flag <= 1'b1;
            end
        end
    end

    AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(wdata))); // R1

    AST_LOAD_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !flag); // R8

    AST_FLAG_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(count) == '0) && (count == '1)); // R4

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (count == '0) && !flag); // R11

endmodule

// File: rtl/tmr_irq.sv
// Module: tmr_irq
// Latches the timer interrupt enable on each load and drives the shared request.
// Assumes the edge-detect source arrives already registered from the port logic.
module tmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic en_wr,
    input  logic timer_flag,
    input  logic edge_flag,
    input  logic edge_en,
    output logic timer_en,
    output logic irq
);

    // Purpose: enable follows address bit 3 of the most recent timer write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_en <= 1'b0;
        end else if (load) begin
            timer_en <= en_wr;
        end
    end

    // Purpose: merge the timer and edge-detect interrupt sources
    always_comb irq = (timer_flag && timer_en) || (edge_flag && edge_en);

    AST_ENABLE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (timer_en == $past(en_wr))); // R6

endmodule

// File: rtl/interval_timer.sv
// Module: interval_timer (top)
// Interval timer with bus decode, prescaler, counter and interrupt merge.
// Assumes single-cycle bus writes sampled on the rising clock edge.
module interval_timer
    import interval_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned SHIFTS [4] = '{0, 3, 6, 10}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              edge_flag,
    input  logic              edge_en,
    output logic              irq
);

    logic             load;
    ivl_sel_t         sel;
    logic             en_wr;
    logic             tick;
    logic [CNT_W-1:0] count;
    logic             timer_flag;
    logic             running;
    logic             timer_en;

    tmr_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(CNT_W)) i_dec (
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .count      (count),
        .timer_flag (timer_flag),
        .edge_flag  (edge_flag),
        .load       (load),
        .sel        (sel),
        .en_wr      (en_wr),
        .bus_rdata  (bus_rdata)
    );

    tmr_prescaler #(.SHIFTS(SHIFTS)) i_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .sel   (sel),
        .fast  (timer_flag),
        .tick  (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .wdata   (bus_wdata),
        .tick    (tick),
        .count   (count),
        .flag    (timer_flag),
        .running (running)
    );

    tmr_irq i_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .en_wr      (en_wr),
        .timer_flag (timer_flag),
        .edge_flag  (edge_flag),
        .edge_en    (edge_en),
        .timer_en   (timer_en),
        .irq        (irq)
    );

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(count)); // R2

    AST_FAST_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_flag && !load) |=> (count == CNT_W'($past(count) - 1'b1))); // R5

    AST_TIMER_DRIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_flag && timer_en) |-> irq); // R9

endmodule

// File: tb/test_interval_timer.sv
// Directed bench: one task per scenario, each checking its own results.
module test_interval_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       edge_flag = 1'b0;
    logic       edge_en = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    interval_timer i_interval_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .edge_flag (edge_flag),
        .edge_en   (edge_en),
        .irq       (irq)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=0x%02h expected=0x%02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        rd(5'h04, v); chk("R11", "count after reset", v, 8'h00);
        rd(5'h05, v); chk("R11", "status after reset", v, 8'h00);
        chk("R11", "irq after reset", {7'd0, irq}, 8'h00);
        step(20);
        rd(5'h04, v); chk("R11", "idle count", v, 8'h00);
        rd(5'h05, v); chk("R11", "idle status", v, 8'h00);
    endtask

    task automatic t_interval(input logic [4:0] a, input logic [7:0] d, input int n, input string req);
        logic [7:0] v;
        wr(a, d);
        rd(5'h04, v); chk("R1", "loaded count", v, d);
        step(n - 1);
        rd(5'h04, v); chk(req, "count before interval", v, d);
        step(1);
        rd(5'h04, v); chk(req, "count after interval", v, d - 8'd1);
    endtask

    task automatic t_restart;
        logic [7:0] v;
        wr(5'h15, 8'd10);
        step(5);
        wr(5'h15, 8'd10);
        step(7);
        rd(5'h04, v); chk("R3", "held after rewrite", v, 8'd10);
        step(1);
        rd(5'h04, v); chk("R3", "decrement full interval after rewrite", v, 8'd9);
    endtask

    task automatic t_expiry_irq;
        logic [7:0] v;
        wr(5'h1C, 8'd1);
        step(1);
        rd(5'h04, v); chk("R4", "count at zero", v, 8'h00);
        rd(5'h05, v); chk("R4", "no flag at zero", v, 8'h00);
        chk("R6", "irq low at zero", {7'd0, irq}, 8'h00);
        step(1);
        rd(5'h04, v); chk("R4", "wrap to ff", v, 8'hFF);
        rd(5'h05, v); chk("R7", "status timer bit", v, 8'h80);
        chk("R6", "irq enabled", {7'd0, irq}, 8'h01);
        wr(5'h1C, 8'd1);
        chk("R8", "irq after rewrite", {7'd0, irq}, 8'h00);
        rd(5'h05, v); chk("R8", "flag after rewrite", v, 8'h00);
    endtask

    task automatic t_irq_disabled;
        logic [7:0] v;
        wr(5'h14, 8'd1);
        step(2);
        rd(5'h05, v); chk("R6", "flag while disabled", v, 8'h80);
        chk("R6", "irq while disabled", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_fast_after;
        logic [7:0] v;
        wr(5'h14, 8'd1);
        step(7);
        rd(5'h04, v); chk("R5", "count after passing zero", v, 8'hFA);
        wr(5'h15, 8'd0);
        step(8);
        rd(5'h04, v); chk("R4", "wrap at slow interval", v, 8'hFF);
        step(1);
        rd(5'h04, v); chk("R5", "single-clock rate after expiry", v, 8'hFE);
    endtask

    task automatic t_edge_source;
        logic [7:0] v;
        wr(5'h17, 8'd50);
        edge_flag = 1'b1; edge_en = 1'b0;
        step(1);
        rd(5'h05, v); chk("R7", "status edge bit", v, 8'h40);
        chk("R9", "edge flag without enable", {7'd0, irq}, 8'h00);
        edge_en = 1'b1;
        step(1);
        chk("R9", "edge source drives irq", {7'd0, irq}, 8'h01);
        rd(5'h00, v); chk("R7", "other offset reads zero", v, 8'h00);
        edge_flag = 1'b0; edge_en = 1'b0;
        step(1);
        chk("R9", "irq released", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_ignored;
        logic [7:0] v;
        wr(5'h17, 8'd50);
        wr(5'h04, 8'd9);
        wr(5'h10, 8'd9);
        wr(5'h0C, 8'd9);
        rd(5'h04, v); chk("R10", "count untouched", v, 8'd50);
        wr(5'h1C, 8'd0);
        step(1);
        chk("R10", "irq set before ignored writes", {7'd0, irq}, 8'h01);
        wr(5'h0F, 8'd7);
        wr(5'h13, 8'd7);
        chk("R10", "irq kept through ignored writes", {7'd0, irq}, 8'h01);
        rd(5'h05, v); chk("R10", "flag kept through ignored writes", v, 8'h80);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_interval(5'h14, 8'd128, 1, "R2");
        t_interval(5'h15, 8'd28, 8, "R2");
        t_interval(5'h16, 8'd5, 64, "R2");
        t_interval(5'h17, 8'd2, 1024, "R2");
        t_restart();
        t_expiry_irq();
        t_irq_disabled();
        t_fast_after();
        t_edge_source();
        t_ignored();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule